// File: doc/BRIEF.md
# Two-Address Temporal Stream Prefetcher

This block learns the order in which cache lines are requested and replays that order as prefetches. Every trigger event, either a demand miss or a hit on a line that was brought in by an earlier prefetch, carries a line address. The address is appended to a 64-entry circular history. Two direct-mapped index tables point back into that history. One is keyed by the trigger address alone. The other is keyed by the previous trigger address and the current one together.

When a demand miss arrives, the block first looks the address up. A hit in the two-address table is preferred over a hit in the one-address table. The block then copies the up to four addresses that followed the matched position in the history into a small pointer buffer. Only after this lookup does it record the new address. The pointer buffer feeds a valid/ready prefetch port, one address per accepted cycle.

A prefetch-hit trigger is recorded in the same way but leaves the buffer alone, so the current stream keeps draining. An index entry whose history slot has since been overwritten by another address is recognised as stale and ignored.

Top module: `tstream_prefetcher`

## Requirements
- R1: In the cycle after reset is released, `pf_valid` is low, and the first demand miss after reset produces no prefetch.
- R2: Every accepted trigger, of either kind, is written at the next history position. The write position advances by one modulo 64, so the 65th trigger overwrites the oldest entry.
- R3: On a demand miss, if the two-address table holds the pair (previous trigger address, current address), the buffer is loaded with the addresses recorded after the position stored in that entry.
- R4: When both tables produce a valid match, the two-address match selects the history position.
- R5: When the two-address table does not match, a valid one-address match selects the history position.
- R6: A demand miss with no valid match in either table empties the buffer, so `pf_valid` is low in the following cycle even if a stream was pending.
- R7: A loaded stream holds min(4, number of entries recorded after the matched position) addresses, in recorded order.
- R8: A prefetch-hit trigger (`trig_kind` = 1) does not reload or clear the buffer. The pending head and count change only by a pop in the same cycle.
- R9: At most one prefetch leaves per cycle. While `pf_valid` is high and `pf_ready` is low, and no demand miss arrives, `pf_valid` and `pf_addr` hold. An accepted prefetch exposes the next buffered address in the following cycle.
- R10: Lookup uses the tables as they stood before the trigger's own recording. For the sequence A, B, A, the second A prefetches B.
- R11: An index entry is valid only if its history slot still holds the looked-up address. An entry whose slot was overwritten yields no prefetch.
- R12: Bit k of the one-address index is the XOR of all address bits i with i mod 4 = k. The two-address index is the current address's index XOR the previous address's index rotated left by one bit. Each entry stores its full key, and a later write to the same index replaces it.
- R13: A demand miss in the same cycle as an accepted prefetch reloads the buffer; the pop is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | A trigger event is present this cycle |
| trig_kind | input | 1 | 0 = demand miss, 1 = hit on a prefetched line |
| trig_addr | input | 32 | Line address of the trigger |
| pf_ready | input | 1 | Downstream accepts the offered prefetch |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_addr | output | 32 | Offered prefetch line address |

## Verification
The assertions assume that `trig_kind` and `trig_addr` are known whenever `trig_valid` is high. They also assume that `pf_ready` is a plain level that the consumer may drop at any time, and that a miss can coincide with a pending or accepted prefetch. The stimulus changes every input only on the falling clock edge. It uses chosen address sets whose index values are worked out in advance, so that collisions, overwrites and wraps happen exactly where a test needs them. It mixes stalled and ready cycles with misses and prefetch-hit triggers arriving mid-stream. A reference model built from the requirements predicts the buffer head and occupancy after each cycle. Directed tests then pin specific expected addresses for the priority, stale-entry and collision cases.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  typedef enum logic {
    TRIG_MISS  = 1'b0,
    TRIG_PFHIT = 1'b1
  } trig_kind_e;
endpackage

// File: rtl/tsp_history.sv
// Circular record of trigger addresses with several asynchronous read ports.
module tsp_history #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 32,
  parameter int POS_W  = 6,
  parameter int NRD    = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_data,
  output logic [POS_W-1:0]            wptr,
  input  logic [NRD-1:0][POS_W-1:0]   rd_pos,
  output logic [NRD-1:0][ADDR_W-1:0]  rd_data
);
  logic [ADDR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        wptr <= '0;
    else if (wr_en) wptr <= wptr + POS_W'(1);
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_pos[g]];
  end
endmodule

// File: rtl/tsp_index_table.sv
// Direct-mapped table from a hashed key to a history position, full key kept.
module tsp_index_table #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int KEY_W = 32,
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [KEY_W-1:0] rd_key,
  output logic             rd_hit,
  output logic [POS_W-1:0] rd_pos,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [POS_W-1:0] wr_pos
);
  logic [DEPTH-1:0] vld;
  logic [KEY_W-1:0] key_mem [DEPTH];
  logic [POS_W-1:0] pos_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_mem[wr_idx] <= wr_key;
      pos_mem[wr_idx] <= wr_pos;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  assign rd_hit = vld[rd_idx] && (key_mem[rd_idx] == rd_key);
  assign rd_pos = pos_mem[rd_idx];
endmodule

// File: rtl/tsp_ptr_buf.sv
// Shift buffer holding the stream being replayed; bulk load, single pop.
module tsp_ptr_buf #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic [CNT_W-1:0]             load_cnt,
  input  logic [DEPTH-1:0][ADDR_W-1:0] load_data,
  input  logic                         pop,
  output logic                         head_valid,
  output logic [ADDR_W-1:0]            head_addr,
  output logic [CNT_W-1:0]             count
);
  logic [ADDR_W-1:0] ent [DEPTH];
  logic              do_pop;

  assign do_pop = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (rst)         count <= '0;
    else if (load)   count <= load_cnt;
    else if (do_pop) count <= count - CNT_W'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i < DEPTH - 1) begin : g_mid
      always_ff @(posedge clk) begin
        if (load)        ent[i] <= load_data[i];
        else if (do_pop) ent[i] <= ent[i+1];
      end
    end else begin : g_last
      always_ff @(posedge clk) begin
        if (load) ent[i] <= load_data[i];
      end
    end
  end

  assign head_valid = (count != '0);
  assign head_addr  = ent[0];
endmodule

// File: rtl/tstream_prefetcher.sv
module tstream_prefetcher
  import tsp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int HIST_DEPTH = 64,
  parameter int IDX_DEPTH  = 16,
  parameter int PBUF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_valid,
  input  logic              trig_kind,
  input  logic [ADDR_W-1:0] trig_addr,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int IDX_W = $clog2(IDX_DEPTH);
  localparam int POS_W = $clog2(HIST_DEPTH);
  localparam int CNT_W = $clog2(PBUF_DEPTH + 1);
  localparam int NRD   = 2 + PBUF_DEPTH;
  localparam int CHUNKS = (ADDR_W + IDX_W - 1) / IDX_W;

  function automatic logic [IDX_W-1:0] fold_addr(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int c = 0; c < CHUNKS; c++) begin
      for (int b = 0; b < IDX_W; b++) begin
        if (c * IDX_W + b < ADDR_W) h[b] = h[b] ^ a[c * IDX_W + b];
      end
    end
    return h;
  endfunction

  function automatic logic [IDX_W-1:0] rotl1(input logic [IDX_W-1:0] h);
    return {h[IDX_W-2:0], h[IDX_W-1]};
  endfunction

  // previous trigger address for the pair key
  logic              prev_vld;
  logic [ADDR_W-1:0] prev_addr;

  logic              miss_trig;
  logic [IDX_W-1:0]  s_idx, p_idx;
  logic              s_hit, p_hit, s_ok, p_ok;
  logic [POS_W-1:0]  s_pos, p_pos, base_pos, avail, hist_wptr;
  logic [CNT_W-1:0]  take_cnt, load_cnt, buf_cnt;
  logic              pop;

  logic [NRD-1:0][POS_W-1:0]         rd_pos;
  logic [NRD-1:0][ADDR_W-1:0]        rd_data;
  logic [PBUF_DEPTH-1:0][ADDR_W-1:0] load_data;

  assign miss_trig = trig_valid && (trig_kind == TRIG_MISS);
  assign s_idx     = fold_addr(trig_addr);
  assign p_idx     = fold_addr(trig_addr) ^ rotl1(fold_addr(prev_addr));

  tsp_index_table #(
    .DEPTH(IDX_DEPTH), .IDX_W(IDX_W), .KEY_W(ADDR_W), .POS_W(POS_W)
  ) single_tbl_i (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (s_idx),
    .rd_key (trig_addr),
    .rd_hit (s_hit),
    .rd_pos (s_pos),
    .wr_en  (trig_valid),
    .wr_idx (s_idx),
    .wr_key (trig_addr),
    .wr_pos (hist_wptr)
  );

  tsp_index_table #(
    .DEPTH(IDX_DEPTH), .IDX_W(IDX_W), .KEY_W(2 * ADDR_W), .POS_W(POS_W)
  ) pair_tbl_i (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (p_idx),
    .rd_key ({prev_addr, trig_addr}),
    .rd_hit (p_hit),
    .rd_pos (p_pos),
    .wr_en  (trig_valid && prev_vld),
    .wr_idx (p_idx),
    .wr_key ({prev_addr, trig_addr}),
    .wr_pos (hist_wptr)
  );

  tsp_history #(
    .DEPTH(HIST_DEPTH), .ADDR_W(ADDR_W), .POS_W(POS_W), .NRD(NRD)
  ) hist_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (trig_valid),
    .wr_data (trig_addr),
    .wptr    (hist_wptr),
    .rd_pos  (rd_pos),
    .rd_data (rd_data)
  );

  // an entry counts only if its history slot still holds the address
  assign p_ok     = prev_vld && p_hit && (rd_data[0] == trig_addr);
  assign s_ok     = s_hit && (rd_data[1] == trig_addr);
  assign base_pos = p_ok ? p_pos : s_pos;
  assign avail    = hist_wptr - base_pos - POS_W'(1);
  assign take_cnt = (avail >= POS_W'(PBUF_DEPTH)) ? CNT_W'(PBUF_DEPTH) : CNT_W'(avail);
  assign load_cnt = (p_ok || s_ok) ? take_cnt : '0;

  assign rd_pos[0] = p_pos;
  assign rd_pos[1] = s_pos;
  for (genvar k = 0; k < PBUF_DEPTH; k++) begin : g_succ
    assign rd_pos[2+k]  = base_pos + POS_W'(k + 1);
    assign load_data[k] = rd_data[2+k];
  end

  assign pop = pf_valid && pf_ready;

  tsp_ptr_buf #(
    .DEPTH(PBUF_DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) pbuf_i (
    .clk        (clk),
    .rst        (rst),
    .load       (miss_trig),
    .load_cnt   (load_cnt),
    .load_data  (load_data),
    .pop        (pop),
    .head_valid (pf_valid),
    .head_addr  (pf_addr),
    .count      (buf_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_vld  <= 1'b0;
      prev_addr <= '0;
    end else if (trig_valid) begin
      prev_vld  <= 1'b1;
      prev_addr <= trig_addr;
    end
  end
endmodule

// File: rtl/tsp_prefetch_chk.sv
module tsp_prefetch_chk
  import tsp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int POS_W      = 6,
  parameter int CNT_W      = 3,
  parameter int PBUF_DEPTH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              trig_valid,
  input logic              trig_kind,
  input logic              pf_ready,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              miss_trig,
  input logic [CNT_W-1:0]  load_cnt,
  input logic [CNT_W-1:0]  buf_cnt,
  input logic [POS_W-1:0]  hist_wptr
);
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pf_valid) else $error("idle after reset"); // R1

  AST_WPTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    trig_valid |=> hist_wptr == $past(hist_wptr) + POS_W'(1)) else $error("wptr advance"); // R2

  AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !trig_valid |=> $stable(hist_wptr)) else $error("wptr hold"); // R2

  AST_EMPTY_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    miss_trig && (load_cnt == '0) |=> !pf_valid) else $error("no-match clear"); // R6

  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (rst)
    miss_trig |=> buf_cnt == $past(load_cnt)) else $error("load count"); // R13

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    buf_cnt <= CNT_W'(PBUF_DEPTH)) else $error("count bound"); // R7

  AST_PFHIT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    trig_valid && (trig_kind == TRIG_PFHIT) && !(pf_valid && pf_ready)
    |=> $stable(buf_cnt) && $stable(pf_addr)) else $error("pfhit keeps"); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    pf_valid && !pf_ready && !miss_trig |=> pf_valid && $stable(pf_addr)) else $error("stall hold"); // R9

  AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
    pf_valid && pf_ready && !miss_trig |=> buf_cnt == $past(buf_cnt) - CNT_W'(1)) else $error("pop one"); // R9
endmodule

bind tstream_prefetcher tsp_prefetch_chk #(
  .ADDR_W(ADDR_W), .POS_W(POS_W), .CNT_W(CNT_W), .PBUF_DEPTH(PBUF_DEPTH)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .trig_valid (trig_valid),
  .trig_kind  (trig_kind),
  .pf_ready   (pf_ready),
  .pf_valid   (pf_valid),
  .pf_addr    (pf_addr),
  .miss_trig  (miss_trig),
  .load_cnt   (load_cnt),
  .buf_cnt    (buf_cnt),
  .hist_wptr  (hist_wptr)
);

// File: tb/tstream_prefetcher_tb.sv
module tstream_prefetcher_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic KM = 1'b0;  // demand miss
  localparam logic KH = 1'b1;  // prefetch hit

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_valid = 1'b0;
  logic        trig_kind = 1'b0;
  logic [31:0] trig_addr = '0;
  logic        pf_ready = 1'b0;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tstream_prefetcher dut_i (
    .clk(clk), .rst(rst), .trig_valid(trig_valid), .trig_kind(trig_kind),
    .trig_addr(trig_addr), .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  // reference model, from the requirements
  logic [31:0] m_hist [64];
  int          m_wptr;
  bit          m_sv [16];
  logic [31:0] m_sk [16];
  int          m_spos [16];
  bit          m_pv [16];
  logic [31:0] m_pkp [16];
  logic [31:0] m_pkc [16];
  int          m_ppos [16];
  logic [31:0] m_prev;
  bit          m_prev_v;
  logic [31:0] mq [4];
  int          mcnt;

  function automatic logic [3:0] fold(input logic [31:0] a);
    logic [3:0] h = '0;
    for (int i = 0; i < 32; i++) h[i % 4] = h[i % 4] ^ a[i];
    return h;
  endfunction

  function automatic logic [3:0] rot(input logic [3:0] h);
    return {h[2:0], h[3]};
  endfunction

  task automatic model_reset();
    m_wptr = 0; m_prev = '0; m_prev_v = 0; mcnt = 0;
    for (int i = 0; i < 16; i++) begin m_sv[i] = 0; m_pv[i] = 0; end
  endtask

  task automatic model_edge(input logic v, input logic k, input logic [31:0] a, input logic rdy);
    logic [3:0] hs, hp;
    bit p_ok, s_ok, pop;
    int base, avail, n;
    hs = fold(a);
    hp = fold(a) ^ rot(fold(m_prev));
    pop = (mcnt > 0) && rdy;
    if (v && k == KM) begin
      p_ok = m_prev_v && m_pv[hp] && m_pkp[hp] == m_prev && m_pkc[hp] == a
             && m_hist[m_ppos[hp]] == a;
      s_ok = m_sv[hs] && m_sk[hs] == a && m_hist[m_spos[hs]] == a;
      base = p_ok ? m_ppos[hp] : m_spos[hs];
      avail = (m_wptr - base - 1) & 63;
      n = (p_ok || s_ok) ? ((avail > 4) ? 4 : avail) : 0;
      for (int j = 0; j < n; j++) mq[j] = m_hist[(base + 1 + j) & 63];
      mcnt = n;
    end else if (pop) begin
      for (int j = 0; j < 3; j++) mq[j] = mq[j+1];
      mcnt = mcnt - 1;
    end
    if (v) begin
      m_hist[m_wptr] = a;
      m_sv[hs] = 1; m_sk[hs] = a; m_spos[hs] = m_wptr;
      if (m_prev_v) begin
        m_pv[hp] = 1; m_pkp[hp] = m_prev; m_pkc[hp] = a; m_ppos[hp] = m_wptr;
      end
      m_wptr = (m_wptr + 1) & 63;
      m_prev = a; m_prev_v = 1;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, clock, update the model, compare away from the edge
  task automatic step(input logic v, input logic k, input logic [31:0] a, input logic rdy, input string tag);
    @(negedge clk);
    trig_valid = v; trig_kind = k; trig_addr = a; pf_ready = rdy;
    @(posedge clk);
    model_edge(v, k, a, rdy);
    #1;
    chk(tag, {31'd0, pf_valid}, {31'd0, mcnt > 0}, "pf_valid");
    if (mcnt > 0) chk(tag, pf_addr, mq[0], "pf_addr");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; trig_valid = 0; pf_ready = 0;
    @(posedge clk); @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
    chk("R1", {31'd0, pf_valid}, 32'd0, "pf_valid after reset");
  endtask

  // {valid, kind, ready, addr}
  localparam int NV = 18;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, KM, 1'b0, 32'hA000_0040}, {1'b1, KM, 1'b0, 32'hA000_0080},
    {1'b1, KM, 1'b0, 32'hA000_00C0}, {1'b1, KM, 1'b0, 32'hA000_0100},
    {1'b1, KM, 1'b0, 32'hA000_0140}, {1'b1, KM, 1'b0, 32'hA000_0180},
    {1'b1, KM, 1'b0, 32'hA000_0040}, {1'b0, KM, 1'b0, 32'h0},
    {1'b1, KH, 1'b1, 32'hA000_0080}, {1'b0, KM, 1'b1, 32'h0},
    {1'b0, KM, 1'b0, 32'h0},         {1'b1, KM, 1'b0, 32'hA000_00C0},
    {1'b0, KM, 1'b1, 32'h0},         {1'b0, KM, 1'b1, 32'h0},
    {1'b0, KM, 1'b1, 32'h0},         {1'b0, KM, 1'b1, 32'h0},
    {1'b0, KM, 1'b1, 32'h0},         {1'b0, KM, 1'b1, 32'h0}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();

    // R1: first miss after reset finds nothing
    step(1, KM, 32'h0000_0777, 0, "R1");
    chk("R1", {31'd0, pf_valid}, 32'd0, "first miss");

    // table walk: record, replay, pair match (R3), stalls and pops (R9)
    for (int i = 0; i < NV; i++)
      step(VEC[i][34], VEC[i][33], VEC[i][31:0], VEC[i][32], "R3");

    // R10 / R5: A, B, A -> single match predicts B, only one entry (R7)
    do_reset();
    step(1, KM, 32'h0000_0100, 0, "R10");
    step(1, KM, 32'h0000_2000, 0, "R10");
    step(1, KM, 32'h0000_0100, 0, "R5");
    chk("R10", pf_addr, 32'h0000_2000, "successor of A");
    step(0, KM, 0, 1, "R7");
    chk("R7", {31'd0, pf_valid}, 32'd0, "short stream drained");

    // R4: pair (X,Y) wins over newer single Y
    do_reset();
    step(1, KM, 32'h0000_0001, 0, "R4");
    step(1, KM, 32'h0000_0020, 0, "R4");
    step(1, KM, 32'h0000_0300, 0, "R4");
    step(1, KM, 32'h0000_4000, 0, "R4");
    step(1, KM, 32'h0000_0020, 0, "R4");
    step(1, KM, 32'h000C_0000, 0, "R4");
    step(1, KM, 32'h0000_0001, 0, "R5");
    chk("R5", pf_addr, 32'h0000_0020, "single match head");
    step(1, KM, 32'h0000_0020, 0, "R4");
    chk("R4", pf_addr, 32'h0000_0300, "pair match head");
    for (int i = 0; i < 4; i++) step(0, KM, 0, 1, "R7");
    chk("R7", {31'd0, pf_valid}, 32'd0, "four entries drained");

    // R8, R9, R13, R6
    do_reset();
    step(1, KM, 32'h0000_1000, 0, "R8");
    step(1, KM, 32'h0000_2000, 0, "R8");
    step(1, KM, 32'h0000_3000, 0, "R8");
    step(1, KM, 32'h0000_4000, 0, "R8");
    step(1, KM, 32'h0000_5000, 0, "R8");
    step(1, KM, 32'h0000_1000, 0, "R7");
    chk("R7", pf_addr, 32'h0000_2000, "head after load");
    step(0, KM, 0, 0, "R9");
    chk("R9", pf_addr, 32'h0000_2000, "held while stalled");
    step(1, KH, 32'h0000_2000, 0, "R8");
    chk("R8", pf_addr, 32'h0000_2000, "prefetch hit keeps head");
    step(0, KM, 0, 1, "R9");
    chk("R9", pf_addr, 32'h0000_3000, "next after pop");
    step(1, KM, 32'h0000_3000, 1, "R13");
    chk("R13", pf_addr, 32'h0000_4000, "reload head");
    step(0, KM, 0, 1, "R13");
    step(0, KM, 0, 1, "R13");
    step(0, KM, 0, 1, "R13");
    chk("R13", pf_addr, 32'h0000_2000, "fourth reloaded entry");
    step(0, KM, 0, 0, "R13");
    step(1, KM, 32'h9999_0000, 0, "R6");
    chk("R6", {31'd0, pf_valid}, 32'd0, "no match clears");

    // R2: wrap, slot 0 still A, successors cross no gap
    do_reset();
    step(1, KM, 32'h0000_0005, 0, "R2");
    for (int i = 1; i < 64; i++) step(1, KM, (i << 8) | i, 0, "R2");
    step(1, KM, 32'h0000_0005, 0, "R2");
    chk("R2", pf_addr, 32'h0000_0101, "after 64 records");

    // R11: slot 0 overwritten -> stale entry ignored
    do_reset();
    step(1, KM, 32'h0000_0005, 0, "R11");
    for (int i = 1; i <= 64; i++) step(1, KM, (i << 8) | i, 0, "R11");
    step(1, KM, 32'h0000_0005, 0, "R11");
    chk("R11", {31'd0, pf_valid}, 32'd0, "stale entry");

    // R12: colliding address replaces the single entry
    do_reset();
    step(1, KM, 32'h0000_0100, 0, "R12");
    step(1, KM, 32'h0000_2000, 0, "R12");
    step(1, KM, 32'h0000_0001, 0, "R12");
    step(1, KM, 32'h0003_0000, 0, "R12");
    step(1, KM, 32'h0000_0100, 0, "R12");
    chk("R12", {31'd0, pf_valid}, 32'd0, "collision replaced entry");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule